// File: doc/BRIEF.md
# Message-Signalled Interrupt File

This block is the per-hart interrupt file that collects message-signalled interrupts. A device raises an interrupt by writing an identity number to the file's memory page. That write sets one pending bit. Each identity also has an enable bit. The file drives a single interrupt line toward the hart. The line is raised when delivery is switched on and at least one identity is pending, enabled and below the priority threshold. Lower identity numbers win.

Software never addresses the file's registers directly. It first loads a select register with a register number. It then reads or modifies that register through a data port. The data port offers read, write, bit-set and bit-clear, and each one is done in a single access. Every access returns the register's previous value, so a clear also serves as an atomic read-and-clear. A claim port reports the winning identity. Acknowledging the claim retires that identity's pending bit.

Top module: `msif_intfile`

## Requirements
- R1: After reset every pending and enable bit is 0, delivery is off, the threshold is 0, the select is 0, `irq` is low and `claim_value` is 0.
- R2: `sel_we` loads the select register at the next clock edge. `data_rdata` shows the current value of the selected register combinationally. When `data_valid` is high, `data_op` (0 read, 1 write, 2 bit-set, 3 bit-clear) is applied to the selected register with `data_wdata` as the operand, and the result is visible after that edge.
- R3: Identity N sits at bit N mod XLEN of array word N/XLEN. Pending word k is at select 0x80 + k*(XLEN/32) and enable word k is at 0xC0 + k*(XLEN/32). Delivery is bit 0 of select 0x70. The threshold is the low $clog2(NUM_IDS+1) bits of select 0x72. Any other select reads 0, and writes to it change nothing.
- R4: Identity 0 is not implemented. Its pending and enable bits always read 0, and writes to them are ignored.
- R5: An MSI write with an identity from 1 to NUM_IDS sets that pending bit at the next edge. Identity 0 and identities above NUM_IDS are ignored.
- R6: `claim_value` holds the lowest-numbered eligible identity in bits 26:16 and again in bits 10:0. It is 0 when no identity is eligible. An identity is eligible when it is pending and enabled.
- R7: An identity is eligible only if the threshold is 0 or the identity is below the threshold. A threshold of 1 blocks every identity.
- R8: `irq` is high exactly when delivery is 1 and `claim_value` is nonzero.
- R9: `claim_ack` clears the pending bit of the identity shown in `claim_value`. It has no effect when `claim_value` is 0.
- R10: An MSI write that lands in the same cycle as a data-port clear or a claim of the same identity leaves that pending bit set.
- R11: A bit-clear access returns the old register value on `data_rdata` during the access and clears the chosen bits at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | MSI page write strobe |
| msi_data | input | 32 | Identity number written to the MSI page |
| sel_we | input | 1 | Load the select register |
| sel_wdata | input | SEL_W | New select value |
| data_valid | input | 1 | Data-port access strobe |
| data_op | input | 2 | Access kind: 0 read, 1 write, 2 set, 3 clear |
| data_wdata | input | XLEN | Operand of the access |
| data_rdata | output | XLEN | Current value of the selected register |
| claim_ack | input | 1 | Retire the identity shown on claim_value |
| claim_value | output | 32 | Winning identity in bits 26:16 and 10:0, or 0 |
| irq | output | 1 | Interrupt request toward the hart |

## Verification
Every state change (select, delivery, threshold, pending and enable bits) takes effect at the first rising edge after the stimulus. `data_rdata`, `claim_value` and `irq` are combinational from that state, so each result is due one edge after its stimulus. The bench drives every input right after a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. The data-port read value is sampled during the access itself, before the edge, because it must show the old contents. The sweeps cover every identity through the MSI port, every claim order and every threshold value.

// File: rtl/msif_pkg.sv
package msif_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } msif_op_e;

    localparam logic [7:0] SEL_DELIVERY  = 8'h70;
    localparam logic [7:0] SEL_THRESHOLD = 8'h72;
    localparam logic [7:0] SEL_PEND_BASE = 8'h80;
    localparam logic [7:0] SEL_EN_BASE   = 8'hC0;

    // Result of one data-port access on a register of up to 64 bits
    function automatic logic [63:0] apply_op(msif_op_e op, logic [63:0] old_v, logic [63:0] arg);
        case (op)
            OP_WRITE: return arg;
            OP_SET:   return old_v | arg;
            OP_CLEAR: return old_v & ~arg;
            default:  return old_v;
        endcase
    endfunction

endpackage

// File: rtl/msif_sel_decode.sv
module msif_sel_decode #(
    parameter int SEL_W  = 8,
    parameter int XLEN   = 32,
    parameter int NWORDS = 2,
    parameter int WIDX_W = 1
) (
    input  logic [SEL_W-1:0]  sel,
    output logic              is_deliv,
    output logic              is_thr,
    output logic              is_pend,
    output logic              is_en,
    output logic [WIDX_W-1:0] word_idx
);
    import msif_pkg::*;

    localparam int STRIDE = XLEN / 32;
    localparam int SHIFT  = $clog2(STRIDE);
    localparam int SPAN   = NWORDS * STRIDE;

    logic [SEL_W-1:0] off_p, off_e;
    logic             in_p, in_e, align_p, align_e;

    assign off_p = sel - SEL_W'(SEL_PEND_BASE);
    assign off_e = sel - SEL_W'(SEL_EN_BASE);
    assign in_p  = (sel >= SEL_W'(SEL_PEND_BASE)) && (off_p < SEL_W'(SPAN));
    assign in_e  = (sel >= SEL_W'(SEL_EN_BASE)) && (off_e < SEL_W'(SPAN));

    generate
        if (STRIDE == 1) begin : g_narrow
            assign align_p = 1'b1;
            assign align_e = 1'b1;
        end else begin : g_wide
            // wide words use only every STRIDE-th select number
            assign align_p = (off_p & SEL_W'(STRIDE - 1)) == '0;
            assign align_e = (off_e & SEL_W'(STRIDE - 1)) == '0;
        end
    endgenerate

    assign is_deliv = (sel == SEL_W'(SEL_DELIVERY));
    assign is_thr   = (sel == SEL_W'(SEL_THRESHOLD));
    assign is_pend  = in_p && align_p;
    assign is_en    = in_e && align_e;
    assign word_idx = is_pend ? WIDX_W'(off_p >> SHIFT) : WIDX_W'(off_e >> SHIFT);

endmodule

// File: rtl/msif_array.sv
module msif_array #(
    parameter int XLEN    = 32,
    parameter int NWORDS  = 2,
    parameter int NUM_IDS = 63,
    parameter int IDW     = 6,
    parameter int WIDX_W  = 1,
    localparam int NBITS  = NWORDS * XLEN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  msif_pkg::msif_op_e  op_kind,
    input  logic [WIDX_W-1:0]   op_idx,
    input  logic [XLEN-1:0]     op_data,
    input  logic                set_valid,
    input  logic [IDW-1:0]      set_id,
    input  logic                clr_valid,
    input  logic [IDW-1:0]      clr_id,
    output logic [NBITS-1:0]    bits
);
    import msif_pkg::*;

    function automatic logic [NBITS-1:0] impl_mask();
        logic [NBITS-1:0] m;
        for (int i = 0; i < NBITS; i++) m[i] = (i >= 1) && (i <= NUM_IDS);
        return m;
    endfunction

    localparam logic [NBITS-1:0] IMPL_MASK = impl_mask();

    logic [NBITS-1:0] bits_d, bits_q, upd;

    generate
        for (genvar w = 0; w < NWORDS; w++) begin : g_word
            assign upd[w*XLEN +: XLEN] = (op_valid && op_idx == WIDX_W'(w))
                ? XLEN'(apply_op(op_kind, 64'(bits_q[w*XLEN +: XLEN]), 64'(op_data)))
                : bits_q[w*XLEN +: XLEN];
        end
    endgenerate

    always_comb begin
        bits_d = upd;
        if (clr_valid) bits_d[clr_id] = 1'b0;
        if (set_valid) bits_d[set_id] = 1'b1;   // a new message wins over any clear
        bits_d = bits_d & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits = bits_q;

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> bits_q[$past(set_id)]); // R10

    AST_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid && !(set_valid && set_id == clr_id) |=> !bits_q[$past(clr_id)]); // R9

    AST_OP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == OP_CLEAR && !set_valid
        |=> (bits_q[$past(op_idx)*XLEN +: XLEN] & $past(op_data)) == '0); // R11

endmodule

// File: rtl/msif_prio.sv
module msif_prio #(
    parameter int NBITS = 64,
    parameter int IDW   = 6
) (
    input  logic [NBITS-1:0] elig,
    output logic             found,
    output logic [IDW-1:0]   top_id
);
    always_comb begin
        found  = 1'b0;
        top_id = '0;
        for (int i = NBITS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found  = 1'b1;
                top_id = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/msif_intfile.sv
module msif_intfile #(
    parameter int XLEN    = 32,
    parameter int NUM_IDS = 63,
    parameter int SEL_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msi_valid,
    input  logic [31:0]      msi_data,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             data_valid,
    input  logic [1:0]       data_op,
    input  logic [XLEN-1:0]  data_wdata,
    output logic [XLEN-1:0]  data_rdata,
    input  logic             claim_ack,
    output logic [31:0]      claim_value,
    output logic             irq
);
    import msif_pkg::*;

    localparam int NWORDS = (NUM_IDS + 1) / XLEN;
    localparam int NBITS  = NWORDS * XLEN;
    localparam int IDW    = $clog2(NUM_IDS + 1);
    localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             deliv;
        logic [IDW-1:0]   thr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              is_deliv, is_thr, is_pend, is_en;
    logic [WIDX_W-1:0] word_idx;
    logic [NBITS-1:0]  pend_bits, en_bits, thr_mask, elig;
    logic              msi_ok, found;
    logic [IDW-1:0]    top_id;
    msif_op_e          op_kind;

    assign op_kind = msif_op_e'(data_op);

    msif_sel_decode #(.SEL_W(SEL_W), .XLEN(XLEN), .NWORDS(NWORDS), .WIDX_W(WIDX_W)) u_dec (
        .sel      (ctl_q.sel),
        .is_deliv (is_deliv),
        .is_thr   (is_thr),
        .is_pend  (is_pend),
        .is_en    (is_en),
        .word_idx (word_idx)
    );

    assign msi_ok = msi_valid && (msi_data != 32'd0) && (msi_data <= 32'(NUM_IDS));

    msif_array #(.XLEN(XLEN), .NWORDS(NWORDS), .NUM_IDS(NUM_IDS), .IDW(IDW), .WIDX_W(WIDX_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (data_valid && is_pend),
        .op_kind   (op_kind),
        .op_idx    (word_idx),
        .op_data   (data_wdata),
        .set_valid (msi_ok),
        .set_id    (msi_data[IDW-1:0]),
        .clr_valid (claim_ack && found),
        .clr_id    (top_id),
        .bits      (pend_bits)
    );

    msif_array #(.XLEN(XLEN), .NWORDS(NWORDS), .NUM_IDS(NUM_IDS), .IDW(IDW), .WIDX_W(WIDX_W)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (data_valid && is_en),
        .op_kind   (op_kind),
        .op_idx    (word_idx),
        .op_data   (data_wdata),
        .set_valid (1'b0),
        .set_id    ('0),
        .clr_valid (1'b0),
        .clr_id    ('0),
        .bits      (en_bits)
    );

    always_comb begin
        for (int i = 0; i < NBITS; i++)
            thr_mask[i] = (ctl_q.thr == '0) || (IDW'(i) < ctl_q.thr);
    end

    assign elig = pend_bits & en_bits & thr_mask;

    msif_prio #(.NBITS(NBITS), .IDW(IDW)) u_prio (
        .elig   (elig),
        .found  (found),
        .top_id (top_id)
    );

    assign claim_value = found ? {16'(top_id), 16'(top_id)} : 32'd0;
    assign irq         = ctl_q.deliv && found;

    always_comb begin
        ctl_d = ctl_q;
        if (sel_we) ctl_d.sel = sel_wdata;
        if (data_valid && is_deliv)
            ctl_d.deliv = apply_op(op_kind, 64'(ctl_q.deliv), 64'(data_wdata)) != 64'd0 ?
                          apply_op(op_kind, 64'(ctl_q.deliv), 64'(data_wdata)) == 64'd1 ||
                          apply_op(op_kind, 64'(ctl_q.deliv), 64'(data_wdata)) % 2 == 64'd1 : 1'b0;
        if (data_valid && is_thr)
            ctl_d.thr = IDW'(apply_op(op_kind, 64'(ctl_q.thr), 64'(data_wdata)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        data_rdata = '0;
        if (is_deliv)     data_rdata = XLEN'(ctl_q.deliv);
        else if (is_thr)  data_rdata = XLEN'(ctl_q.thr);
        else if (is_pend) data_rdata = pend_bits[word_idx*XLEN +: XLEN];
        else if (is_en)   data_rdata = en_bits[word_idx*XLEN +: XLEN];
    end

    AST_IRQ_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctl_q.deliv && pend_bits[top_id] && en_bits[top_id]); // R8

    AST_CLAIM_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
        claim_value != 32'd0 |-> (ctl_q.thr == '0) || (claim_value[IDW-1:0] < ctl_q.thr)); // R7

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we |=> $stable(ctl_q.sel)); // R2

    AST_BAD_MSI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid && !msi_ok && !data_valid && !claim_ack |=> $stable(pend_bits)); // R5

endmodule

// File: tb/test_msif_intfile.sv
module test_msif_intfile;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        msi_valid;
    logic [31:0] msi_data;
    logic        sel_we;
    logic [7:0]  sel_wdata;
    logic        data_valid;
    logic [1:0]  data_op;
    logic [31:0] data_wdata;
    logic [31:0] data_rdata;
    logic        claim_ack;
    logic [31:0] claim_value;
    logic        irq;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    msif_intfile #(.XLEN(32), .NUM_IDS(63), .SEL_W(8)) i_msif_intfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .msi_valid   (msi_valid),
        .msi_data    (msi_data),
        .sel_we      (sel_we),
        .sel_wdata   (sel_wdata),
        .data_valid  (data_valid),
        .data_op     (data_op),
        .data_wdata  (data_wdata),
        .data_rdata  (data_rdata),
        .claim_ack   (claim_ack),
        .claim_value (claim_value),
        .irq         (irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic set_sel(input logic [7:0] s);
        sel_we = 1'b1; sel_wdata = s;
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    task automatic do_op(input logic [1:0] op, input logic [31:0] d);
        data_valid = 1'b1; data_op = op; data_wdata = d;
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    task automatic access(input logic [7:0] s, input logic [1:0] op, input logic [31:0] d);
        set_sel(s);
        do_op(op, d);
    endtask

    task automatic read_reg(input logic [7:0] s, output logic [31:0] v);
        set_sel(s);
        v = data_rdata;
    endtask

    task automatic send_msi(input logic [31:0] id);
        msi_valid = 1'b1; msi_data = id;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    task automatic ack;
        claim_ack = 1'b1;
        @(negedge clk);
        claim_ack = 1'b0;
    endtask

    function automatic logic [31:0] cval(input int k);
        return (k == 0) ? 32'd0 : ((32'(k) << 16) | 32'(k));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, w0, w1;
        rst_n = 1'b0; msi_valid = 0; msi_data = 0; sel_we = 0; sel_wdata = 0;
        data_valid = 0; data_op = 0; data_wdata = 0; claim_ack = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(32'(irq), 0, "R1 irq after reset");
        check(claim_value, 0, "R1 claim after reset");
        check(data_rdata, 0, "R1 select 0 reads zero");
        foreach (v[i]) ;
        read_reg(8'h80, v); check(v, 0, "R1 pending word0");
        read_reg(8'h81, v); check(v, 0, "R1 pending word1");
        read_reg(8'hC0, v); check(v, 0, "R1 enable word0");
        read_reg(8'hC1, v); check(v, 0, "R1 enable word1");
        read_reg(8'h70, v); check(v, 0, "R1 delivery");
        read_reg(8'h72, v); check(v, 0, "R1 threshold");

        // R4 identity 0, R11 read-and-clear
        access(8'h80, 2'd1, 32'hFFFF_FFFF);
        check(data_rdata, 32'hFFFF_FFFE, "R4 id0 pending bit stays 0");
        data_valid = 1'b1; data_op = 2'd3; data_wdata = 32'hFFFF_FFFF;
        #1 check(data_rdata, 32'hFFFF_FFFE, "R11 clear returns old value");
        @(negedge clk); data_valid = 1'b0;
        check(data_rdata, 0, "R11 clear took effect");
        access(8'hC0, 2'd1, 32'h0000_0001);
        check(data_rdata, 0, "R4 id0 enable bit stays 0");

        // R5/R3 MSI sweep over all identities and beyond
        for (int id = 0; id <= 70; id++) begin
            send_msi(32'(id));
            read_reg(8'h80, w0);
            read_reg(8'h81, w1);
            check(w0, (id >= 1 && id < 32) ? (32'd1 << id) : 32'd0, $sformatf("R5 R3 msi id %0d word0", id));
            check(w1, (id >= 32 && id <= 63) ? (32'd1 << (id - 32)) : 32'd0, $sformatf("R5 R3 msi id %0d word1", id));
            access(8'h80, 2'd1, 0);
            access(8'h81, 2'd1, 0);
        end
        send_msi(32'h0001_0005);
        read_reg(8'h80, v); check(v, 0, "R5 large identity ignored");

        // R2 set / clear / write on enable words
        access(8'hC1, 2'd1, 32'h1234_5678);
        check(data_rdata, 32'h1234_5678, "R2 write enable word1");
        do_op(2'd2, 32'h0000_00F0);
        check(data_rdata, 32'h1234_56F8, "R2 bit-set");
        do_op(2'd3, 32'h1200_0008);
        check(data_rdata, 32'h0034_56F0, "R2 bit-clear");
        do_op(2'd0, 32'hFFFF_FFFF);
        check(data_rdata, 32'h0034_56F0, "R2 read leaves value");

        // R3 unimplemented selects
        access(8'h82, 2'd1, 32'hFFFF_FFFF);
        check(data_rdata, 0, "R3 select 0x82 reads zero");
        read_reg(8'h80, v); check(v, 0, "R3 0x82 write left word0");
        read_reg(8'h81, v); check(v, 0, "R3 0x82 write left word1");
        access(8'h71, 2'd1, 32'h1);
        check(data_rdata, 0, "R3 select 0x71 reads zero");
        read_reg(8'h70, v); check(v, 0, "R3 0x71 write left delivery");
        access(8'h72, 2'd1, 32'h0000_00C5);
        check(data_rdata, 32'h05, "R3 threshold keeps low 6 bits");
        access(8'h72, 2'd1, 0);

        // R6/R9/R8 priority sweep
        access(8'hC0, 2'd1, 32'hFFFF_FFFF);
        access(8'hC1, 2'd1, 32'hFFFF_FFFF);
        access(8'h80, 2'd1, 32'hFFFF_FFFF);
        access(8'h81, 2'd1, 32'hFFFF_FFFF);
        access(8'h70, 2'd1, 32'h1);
        for (int k = 1; k <= 63; k++) begin
            check(claim_value, cval(k), $sformatf("R6 claim order step %0d", k));
            check(32'(irq), 1, $sformatf("R8 irq with id %0d", k));
            ack;
        end
        check(claim_value, 0, "R9 all claimed");
        check(32'(irq), 0, "R8 irq low when none");

        // R9 ack with nothing eligible
        access(8'hC0, 2'd1, 32'h0000_0080);
        access(8'hC1, 2'd1, 0);
        send_msi(5);
        check(claim_value, 0, "R6 pending but disabled not claimed");
        ack;
        read_reg(8'h80, v); check(v, 32'h20, "R9 empty ack keeps pending");
        access(8'h80, 2'd1, 0);

        // R7 threshold sweep, pending ids 10 and 40, all enabled
        access(8'hC0, 2'd1, 32'hFFFF_FFFF);
        access(8'hC1, 2'd1, 32'hFFFF_FFFF);
        send_msi(10);
        send_msi(40);
        for (int t = 0; t <= 63; t++) begin
            int e;
            access(8'h72, 2'd1, 32'(t));
            e = 0;
            if (t == 0 || 40 < t) e = 40;
            if (t == 0 || 10 < t) e = 10;
            check(claim_value, cval(e), $sformatf("R7 claim at threshold %0d", t));
            check(32'(irq), 32'(e != 0), $sformatf("R7 R8 irq at threshold %0d", t));
        end
        access(8'h72, 2'd1, 0);

        // R8 delivery off
        access(8'h70, 2'd1, 0);
        check(claim_value, cval(10), "R8 claim independent of delivery");
        check(32'(irq), 0, "R8 irq low with delivery off");
        access(8'h70, 2'd2, 32'h1);
        check(32'(irq), 1, "R8 irq with delivery set");
        access(8'h80, 2'd1, 0);
        access(8'h81, 2'd1, 0);

        // R10 same-cycle collisions
        send_msi(3);
        send_msi(4);
        set_sel(8'h80);
        msi_valid = 1'b1; msi_data = 3;
        data_valid = 1'b1; data_op = 2'd3; data_wdata = 32'h18;
        @(negedge clk);
        msi_valid = 1'b0; data_valid = 1'b0;
        check(data_rdata, 32'h08, "R10 msi beats data clear");
        check(claim_value, cval(3), "R10 claim shows id 3");
        msi_valid = 1'b1; msi_data = 3; claim_ack = 1'b1;
        @(negedge clk);
        msi_valid = 1'b0; claim_ack = 1'b0;
        check(data_rdata, 32'h08, "R10 msi beats claim");
        ack;
        check(data_rdata, 0, "R9 claim clears id 3");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule